// File: doc/BRIEF.md
# System-to-Local Address Translator

This block converts addresses between the system view and one memory node's local view. In the forward direction it takes a 64-bit system address that is already known to belong to this node. It first undoes the relocation that memory hoisting applies, or, outside the relocated window, subtracts the node's base. It then removes the node-interleave bits just above the 4 KiB page offset. The result is the input address that chip-select decoding consumes. In the reverse direction it rebuilds a system address from an input address. It reinserts this node's interleave select bits at bit 12, adds either the hole offset or the node base, and sign-extends the 40-bit physical result to 64 bits.

Each request is one strobe with a direction bit and an address. The configuration inputs are read in the same cycle. The block uses a small three-state machine. ST_IDLE has no result. ST_FWD_OUT holds a forward result. ST_REV_OUT holds a reverse result. On every clock edge the next state is ST_FWD_OUT when a forward request is strobed, ST_REV_OUT when a reverse request is strobed, and ST_IDLE when no request is strobed. These transitions apply from any state, so back-to-back requests can be issued every cycle. Choosing the node and matching the chip-select row are handled elsewhere.

Top module: `addr_xlate_top`

## Requirements
- R1: After reset, and in every cycle in which `out_valid` is low, `out_addr` reads zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after a cycle without one.
- R3: Forward with `cfg_hole_en`=1: if the address is at least 0x1_0000_0000 and below 0x1_0000_0000 + (2^32 − `cfg_hole_base`), the local address is the address minus `cfg_hole_offset`.
- R4: Forward outside that window, the local address is (address AND 0xFF_FFFF_FFFF) minus `cfg_node_base`.
- R5: The interleave shift is taken from `cfg_ilv_en`: 1 gives 1, 3 gives 2, 7 gives 3, and every other code gives 0.
- R6: The forward result is ((local >> shift) AND 0xF_FFFF_F000) + (local AND 0xFFF). Bits 11:0 are never shifted, and bits 63:36 of a forward result are zero.
- R7: Reverse with shift 0 uses the input address unchanged as the local address.
- R8: Reverse with shift s>0 forms the local address as ((in AND 0xF_FFFF_F000) << s) + (in AND 0xFFF) + ((`cfg_ilv_sel` AND (2^s−1)) << 12).
- R9: Reverse: a local address in [`cfg_hole_base`, 2^32) with `cfg_hole_en`=1 has `cfg_hole_offset` added. Any other local address has `cfg_node_base` added.
- R10: When bit 39 of a reverse sum is 1, bits 63:40 of the output are all ones. Otherwise the sum is passed through.
- R11: `req_dir`=0 selects forward (system to input address) and `req_dir`=1 selects reverse.
- R12: With `cfg_hole_en`=0 the relocation window has no effect in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dir | input | 1 | 0 = forward, 1 = reverse |
| req_addr | input | 64 | System address (forward) or input address (reverse) |
| cfg_hole_en | input | 1 | Relocation window enable |
| cfg_hole_base | input | 32 | Start of the hole below 4 GiB |
| cfg_hole_offset | input | 40 | Distance between relocated and local addresses |
| cfg_node_base | input | 40 | Lowest system address of this node |
| cfg_ilv_en | input | 3 | Interleave enable code |
| cfg_ilv_sel | input | 3 | This node's interleave select value |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Translated address |

## Verification
The checker assumes that the configuration follows the granularity of the real registers. The node base, hole base and hole offset are multiples of 16 MiB, so the base never disturbs the page-offset bits. The checker's page-offset property only applies when that holds and the hole is disabled. The stimulus builds every base and offset from 16 MiB-aligned random fields. It draws addresses from three ranges: fully random, inside the relocation window, and the low 40-bit space. This keeps the wrap-around arithmetic in both directions on the exercised paths.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FWD_OUT = 2'd1,
        ST_REV_OUT = 2'd2
    } xl_state_e;

    typedef enum logic {
        DIR_TO_LOCAL  = 1'b0,
        DIR_TO_SYSTEM = 1'b1
    } xl_dir_e;

    // interleave enable code to number of squeezed address bits
    function automatic logic [1:0] ilv_shift(input logic [2:0] code);
        logic [1:0] s;
        unique case (code)
            3'd1:    s = 2'd1;
            3'd3:    s = 2'd2;
            3'd7:    s = 2'd3;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xlate_fwd.sv
module xlate_fwd #(
    parameter int ADDR_W  = 64,
    parameter int PHYS_W  = 40,
    parameter int HOLE_W  = 32,
    parameter int PAGE_W  = 12,
    parameter int LOCAL_W = 36
) (
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              hole_en,
    input  logic [HOLE_W-1:0] hole_base,
    input  logic [PHYS_W-1:0] hole_offset,
    input  logic [PHYS_W-1:0] node_base,
    input  logic [2:0]        ilv_en,
    output logic [ADDR_W-1:0] in_addr
);
    import xlate_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_LO     = ADDR_W'(1) << HOLE_W;
    localparam logic [ADDR_W-1:0] PHYS_MASK  = (ADDR_W'(1) << PHYS_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PAGE_MASK  = (ADDR_W'(1) << PAGE_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FIELD_MASK = ((ADDR_W'(1) << LOCAL_W) - ADDR_W'(1)) & ~PAGE_MASK;

    logic [ADDR_W-1:0] hole_size;
    logic [ADDR_W-1:0] win_hi;
    logic              hole_hit;
    logic [ADDR_W-1:0] node_local;
    logic [ADDR_W-1:0] squeezed;
    logic [1:0]        sh;

    always_comb begin
        hole_size = WIN_LO - ADDR_W'(hole_base);
        win_hi    = WIN_LO + hole_size;
        hole_hit  = hole_en && (sys_addr >= WIN_LO) && (sys_addr < win_hi);
        if (hole_hit) begin
            node_local = sys_addr - ADDR_W'(hole_offset);
        end else begin
            node_local = (sys_addr & PHYS_MASK) - ADDR_W'(node_base);
        end
        sh       = ilv_shift(ilv_en);
        squeezed = node_local >> sh;
        in_addr  = (squeezed & FIELD_MASK) | (node_local & PAGE_MASK);
    end

endmodule

// File: rtl/xlate_rev.sv
module xlate_rev #(
    parameter int ADDR_W  = 64,
    parameter int PHYS_W  = 40,
    parameter int HOLE_W  = 32,
    parameter int PAGE_W  = 12,
    parameter int LOCAL_W = 36
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              hole_en,
    input  logic [HOLE_W-1:0] hole_base,
    input  logic [PHYS_W-1:0] hole_offset,
    input  logic [PHYS_W-1:0] node_base,
    input  logic [2:0]        ilv_en,
    input  logic [2:0]        ilv_sel,
    output logic [ADDR_W-1:0] sys_addr
);
    import xlate_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_LO     = ADDR_W'(1) << HOLE_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK  = (ADDR_W'(1) << PAGE_W) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FIELD_MASK = ((ADDR_W'(1) << LOCAL_W) - ADDR_W'(1)) & ~PAGE_MASK;
    localparam logic [ADDR_W-1:0] EXT_MASK   = ~((ADDR_W'(1) << PHYS_W) - ADDR_W'(1));

    logic [1:0]        sh;
    logic [2:0]        sel_mask;
    logic [ADDR_W-1:0] node_local;
    logic              in_hole;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        sh       = ilv_shift(ilv_en);
        sel_mask = 3'((4'd1 << sh) - 4'd1);
        if (sh == 2'd0) begin
            node_local = in_addr;
        end else begin
            node_local = ((in_addr & FIELD_MASK) << sh)
                       + (in_addr & PAGE_MASK)
                       + (ADDR_W'(ilv_sel & sel_mask) << PAGE_W);
        end
        in_hole = hole_en && (node_local >= ADDR_W'(hole_base)) && (node_local < WIN_LO);
        if (in_hole) begin
            sum = node_local + ADDR_W'(hole_offset);
        end else begin
            sum = node_local + ADDR_W'(node_base);
        end
        sys_addr = sum[PHYS_W-1] ? (sum | EXT_MASK) : sum;
    end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [ADDR_W-1:0] fwd_res,
    input  logic [ADDR_W-1:0] rev_res,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    import xlate_pkg::*;

    xl_state_e         state_q;
    xl_state_e         state_d;
    logic [ADDR_W-1:0] res_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_FWD_OUT, ST_REV_OUT: begin
                if (req_valid) begin
                    state_d = (xl_dir_e'(req_dir) == DIR_TO_SYSTEM) ? ST_REV_OUT : ST_FWD_OUT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                res_q <= (xl_dir_e'(req_dir) == DIR_TO_SYSTEM) ? rev_res : fwd_res;
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_addr  = '0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
                out_addr  = '0;
            end
            ST_FWD_OUT, ST_REV_OUT: begin
                out_valid = 1'b1;
                out_addr  = res_q;
            end
            default: begin
                out_valid = 1'b0;
                out_addr  = '0;
            end
        endcase
    end

endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top #(
    parameter int ADDR_W  = 64,
    parameter int PHYS_W  = 40,
    parameter int HOLE_W  = 32,
    parameter int PAGE_W  = 12,
    parameter int LOCAL_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_hole_en,
    input  logic [HOLE_W-1:0] cfg_hole_base,
    input  logic [PHYS_W-1:0] cfg_hole_offset,
    input  logic [PHYS_W-1:0] cfg_node_base,
    input  logic [2:0]        cfg_ilv_en,
    input  logic [2:0]        cfg_ilv_sel,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);

    logic [ADDR_W-1:0] fwd_res;
    logic [ADDR_W-1:0] rev_res;

    xlate_fwd #(
        .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .HOLE_W(HOLE_W),
        .PAGE_W(PAGE_W), .LOCAL_W(LOCAL_W)
    ) u_fwd (
        .sys_addr    (req_addr),
        .hole_en     (cfg_hole_en),
        .hole_base   (cfg_hole_base),
        .hole_offset (cfg_hole_offset),
        .node_base   (cfg_node_base),
        .ilv_en      (cfg_ilv_en),
        .in_addr     (fwd_res)
    );

    xlate_rev #(
        .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .HOLE_W(HOLE_W),
        .PAGE_W(PAGE_W), .LOCAL_W(LOCAL_W)
    ) u_rev (
        .in_addr     (req_addr),
        .hole_en     (cfg_hole_en),
        .hole_base   (cfg_hole_base),
        .hole_offset (cfg_hole_offset),
        .node_base   (cfg_node_base),
        .ilv_en      (cfg_ilv_en),
        .ilv_sel     (cfg_ilv_sel),
        .sys_addr    (rev_res)
    );

    xlate_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_dir   (req_dir),
        .fwd_res   (fwd_res),
        .rev_res   (rev_res),
        .out_valid (out_valid),
        .out_addr  (out_addr)
    );

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int ADDR_W  = 64,
    parameter int PHYS_W  = 40,
    parameter int PAGE_W  = 12,
    parameter int LOCAL_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_dir,
    input logic [PAGE_W-1:0] req_page,
    input logic              hole_en,
    input logic [PAGE_W-1:0] base_page,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr
);

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r2_idle_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    a_r1_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_addr == '0));

    a_r6_fwd_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(req_dir)) |-> (out_addr[ADDR_W-1:LOCAL_W] == '0));

    a_r6_fwd_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(req_dir) && !$past(hole_en) && ($past(base_page) == '0))
        |-> (out_addr[PAGE_W-1:0] == $past(req_page)));

    a_r10_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_dir) && out_addr[PHYS_W-1]) |-> (&out_addr[ADDR_W-1:PHYS_W]));

endmodule

bind addr_xlate_top xlate_chk #(
    .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .LOCAL_W(LOCAL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dir   (req_dir),
    .req_page  (req_addr[PAGE_W-1:0]),
    .hole_en   (cfg_hole_en),
    .base_page (cfg_node_base[PAGE_W-1:0]),
    .out_valid (out_valid),
    .out_addr  (out_addr)
);

// File: tb/tb_addr_xlate_top.sv
`timescale 1ns/1ps
module tb_addr_xlate_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_dir;
    logic [63:0] req_addr;
    logic        cfg_hole_en;
    logic [31:0] cfg_hole_base;
    logic [39:0] cfg_hole_offset;
    logic [39:0] cfg_node_base;
    logic [2:0]  cfg_ilv_en;
    logic [2:0]  cfg_ilv_sel;
    logic        out_valid;
    logic [63:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    addr_xlate_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
        .req_addr(req_addr), .cfg_hole_en(cfg_hole_en), .cfg_hole_base(cfg_hole_base),
        .cfg_hole_offset(cfg_hole_offset), .cfg_node_base(cfg_node_base),
        .cfg_ilv_en(cfg_ilv_en), .cfg_ilv_sel(cfg_ilv_sel),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic int shift_of(input logic [2:0] c);
        if (c == 3'd1) return 1;
        if (c == 3'd3) return 2;
        if (c == 3'd7) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] exp_fwd(input logic [63:0] a);
        logic [63:0] lo, sz, l;
        int s;
        lo = 64'h1_0000_0000;
        sz = lo - {32'd0, cfg_hole_base};
        if (cfg_hole_en && a >= lo && a < lo + sz) l = a - {24'd0, cfg_hole_offset};
        else l = (a & 64'hFF_FFFF_FFFF) - {24'd0, cfg_node_base};
        s = shift_of(cfg_ilv_en);
        return ((l >> s) & 64'hF_FFFF_F000) + (l & 64'hFFF);
    endfunction

    function automatic logic [63:0] exp_rev(input logic [63:0] a);
        logic [63:0] d, r;
        int s;
        s = shift_of(cfg_ilv_en);
        if (s == 0) d = a;
        else d = ((a & 64'hF_FFFF_F000) << s) + (a & 64'hFFF)
               + (64'(cfg_ilv_sel & 3'((1 << s) - 1)) << 12);
        if (cfg_hole_en && d >= {32'd0, cfg_hole_base} && d < 64'h1_0000_0000)
            r = d + {24'd0, cfg_hole_offset};
        else r = d + {24'd0, cfg_node_base};
        if (r[39]) r[63:40] = 24'hFF_FFFF;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
        end
    endtask

    // issue one request and check the registered result and the idle cycle after it
    task automatic run(input string tag, input logic dir, input logic [63:0] a,
                       input logic [63:0] exp);
        @(negedge clk);
        req_valid = 1'b1;
        req_dir   = dir;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, out_addr, exp);
        @(negedge clk);
        check("R2 idle after request", {63'd0, out_valid}, 64'd0);
        check("R1 zero when idle", out_addr, 64'd0);
    endtask

    task automatic set_cfg(input logic he, input logic [31:0] hb, input logic [39:0] ho,
                           input logic [39:0] nb, input logic [2:0] ie, input logic [2:0] is);
        cfg_hole_en = he; cfg_hole_base = hb; cfg_hole_offset = ho;
        cfg_node_base = nb; cfg_ilv_en = ie; cfg_ilv_sel = is;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 1'b0; req_dir = 1'b0; req_addr = '0;
        set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'd0, 3'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset addr", out_addr, 64'd0);

        // R3 R11: forward through the relocation window
        set_cfg(1'b1, 32'hC000_0000, 40'h00_4000_0000, 40'd0, 3'd0, 3'd0);
        run("R3 fwd hole hit", 1'b0, 64'h1_2345_6789, 64'hE345_6789);
        // R12: same address with hole disabled uses the base
        set_cfg(1'b0, 32'hC000_0000, 40'h00_4000_0000, 40'h01_0000_0000, 3'd0, 3'd0);
        run("R12 fwd hole disabled", 1'b0, 64'h1_2345_6789, 64'h2345_6789);
        // R4: upper bits dropped above bit 39
        set_cfg(1'b1, 32'hC000_0000, 40'h00_4000_0000, 40'h02_0000_0000, 3'd0, 3'd0);
        run("R4 fwd mask and base", 1'b0, 64'hFFFF_FF02_0000_1234, 64'h1234);
        // R5 R6: shift 2 keeps page offset
        set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'd3, 3'd0);
        run("R6 fwd squeeze shift2", 1'b0, 64'h1_2345_6ABC, 64'h48D1_5ABC);
        // R5: every interleave code
        for (int c = 0; c < 8; c++) begin
            set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'(c), 3'd0);
            run("R5 shift code", 1'b0, 64'h0F_8765_4321, exp_fwd(64'h0F_8765_4321));
        end
        // R7: reverse pass-through
        set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'd2, 3'd7);
        run("R7 rev shift0", 1'b1, 64'h0_1234_5ABC, 64'h0_1234_5ABC);
        // R8: select bits reinserted at bit 12
        set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'd7, 3'd5);
        run("R8 rev reinsert sel", 1'b1, 64'h2ABC, 64'h1_5ABC);
        set_cfg(1'b0, 32'd0, 40'd0, 40'd0, 3'd1, 3'd7);
        run("R8 rev sel masked", 1'b1, 64'h2ABC, 64'h5ABC);
        // R9: reverse hole offset
        set_cfg(1'b1, 32'hC000_0000, 40'h00_4000_0000, 40'h00_1000_0000, 3'd0, 3'd0);
        run("R9 rev hole", 1'b1, 64'hC100_0000, 64'h1_0100_0000);
        run("R9 rev below hole", 1'b1, 64'h100_0000, 64'h1100_0000);
        // R10: sign extension from bit 39
        set_cfg(1'b0, 32'd0, 40'd0, 40'h80_0000_0000, 3'd0, 3'd0);
        run("R10 rev sign ext", 1'b1, 64'h1000, 64'hFFFF_FF80_0000_1000);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic        d;
            int          pick;
            set_cfg(1'($urandom), {8'($urandom), 24'd0}, {16'($urandom), 24'd0},
                    {16'($urandom), 24'd0}, 3'($urandom), 3'($urandom));
            pick = $urandom % 3;
            if (pick == 0)      a = {32'($urandom), 32'($urandom)};
            else if (pick == 1) a = 64'h1_0000_0000 + 64'($urandom);
            else                a = {24'd0, 8'($urandom), 32'($urandom)};
            d = 1'($urandom);
            run(d ? "R9 R10 rev random" : "R3 R4 fwd random", d, a, d ? exp_rev(a) : exp_fwd(a));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule